// File: doc/BRIEF.md
# Priority Locality Access Arbiter

The block decides which of five localities (0 to 4, 4 highest) currently owns a shared secure module. Each locality writes its own control register to ask for access, give access up or take it by force, and reads its own status register to learn whether it holds the grant or has lost it to a higher locality. A single state register, readable by any locality, shows whether an owner exists, which locality it is, and the established flag.

Requests are queued as pending bits. Whenever nobody owns the module, the highest pending locality is granted on the next clock. A higher locality may seize ownership outright; the victim keeps a been-seized flag until it asks again. The established flag powers up set. A hash-end pulse clears it, and a privileged write from locality 3 or 4 sets it again.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the module, every been-seized flag is clear, the established flag is 1 and rdata_o is 0.
- R2: A request (control write, addr 0, data bit0 = 1) from a locality while no owner exists grants that locality on the clock after the write; the state register (addr 2) then reads bit7 = 1, bits 4:2 = owner index, bit1 = 1, bit0 = established flag, and the owner's status register (addr 1) reads bit0 = 1.
- R3: Requests made while another locality owns the module stay pending; once the module is free, the highest-numbered pending locality is granted, and lower ones stay queued for later.
- R4: Relinquish (data bit1 = 1) frees the module only when written by the owner; from any other locality it is ignored.
- R5: Seize (data bit2 = 1) transfers ownership to the writer on the next clock only if a locality owns the module and the writer's index is higher; otherwise it is ignored.
- R6: A locality that loses ownership through a seize reads status bit1 = 1 until it writes a new request, which clears it.
- R7: Reset-establishment (data bit3 = 1) sets the established flag only when written from locality 3 or 4.
- R8: A hash_end_i pulse clears the established flag on the next clock and wins over a reset-establishment write in the same cycle.
- R9: Reads are registered: rdata_o takes the addressed value on the clock after rd_i and holds otherwise; the control register reads 0, and a locality index above 4 has writes ignored and reads its status as 0.
- R10: Within one control write, relinquish takes precedence over seize, and seize over request; only the first applicable action of that order is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_i | input | 3 | Locality issuing the access |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 state |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| hash_end_i | input | 1 | Hash-end event pulse |

## Verification
The bench targets the queue: a design that granted in arrival order, or dropped lower requests when the owner left, would hand the module to the wrong locality after a relinquish. Seizes from a lower locality or from a non-owner relinquish must leave ownership untouched; a design that compared priority the wrong way round would move the owner. The been-seized flag is checked to survive an unrelated relinquish and to clear only on the victim's own request, and a combined seize-plus-request write is followed by a relinquish that would re-grant the writer if the request had also been queued. Establishment writes from locality 2 and a same-cycle hash-end and set expose a design that ignored privilege or ordered the two events wrongly.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned N_LOC    = 5;
  localparam int unsigned LW       = $clog2(N_LOC);
  localparam int unsigned DW       = 8;
  localparam int unsigned PRIV_MIN = 3;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_STATE = 2'd2
  } reg_sel_e;

  // matches data bits 3:0 of a control write
  typedef struct packed {
    logic rst_est;
    logic seize;
    logic relinq;
    logic req;
  } ctl_cmd_t;
endpackage

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/loc_owner_ctl.sv
module loc_owner_ctl
  import loc_arb_pkg::*;
#(
  parameter int unsigned N  = N_LOC,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_vld_i,
  input  logic [IW-1:0] wr_loc_i,
  input  ctl_cmd_t      cmd_i,
  output logic          own_vld_o,
  output logic [IW-1:0] own_loc_o,
  output logic [N-1:0]  seized_o
);
  logic [N-1:0]  pend_q, pend_n, seized_q, seized_n;
  logic          own_vld_q, own_vld_n;
  logic [IW-1:0] own_loc_q, own_loc_n;
  logic          pick_any;
  logic [IW-1:0] pick_idx;

  loc_prio_pick #(.N(N), .IW(IW)) u_pick (
    .req_i(pend_q),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  always_comb begin
    pend_n    = pend_q;
    seized_n  = seized_q;
    own_vld_n = own_vld_q;
    own_loc_n = own_loc_q;
    if (!own_vld_q && pick_any) begin
      own_vld_n        = 1'b1;
      own_loc_n        = pick_idx;
      pend_n[pick_idx] = 1'b0;
    end
    if (wr_vld_i) begin
      if (cmd_i.relinq) begin
        if (own_vld_q && own_loc_q == wr_loc_i) own_vld_n = 1'b0;
      end else if (cmd_i.seize) begin
        if (own_vld_q && wr_loc_i > own_loc_q) begin
          seized_n[own_loc_q] = 1'b1;
          own_loc_n           = wr_loc_i;
          pend_n[wr_loc_i]    = 1'b0;
        end
      end else if (cmd_i.req) begin
        seized_n[wr_loc_i] = 1'b0;
        if (!(own_vld_n && own_loc_n == wr_loc_i)) pend_n[wr_loc_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      seized_q  <= '0;
      own_vld_q <= 1'b0;
      own_loc_q <= '0;
    end else begin
      pend_q    <= pend_n;
      seized_q  <= seized_n;
      own_vld_q <= own_vld_n;
      own_loc_q <= own_loc_n;
    end
  end

  assign own_vld_o = own_vld_q;
  assign own_loc_o = own_loc_q;
  assign seized_o  = seized_q;
endmodule

// File: rtl/loc_est_flag.sv
module loc_est_flag #(
  parameter int unsigned IW       = 3,
  parameter int unsigned PRIV_LOC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_req_i,
  input  logic [IW-1:0] set_loc_i,
  input  logic          hash_end_i,
  output logic          est_o
);
  logic est_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   est_q <= 1'b1;
    else if (hash_end_i)                           est_q <= 1'b0;
    else if (set_req_i && set_loc_i >= IW'(PRIV_LOC)) est_q <= 1'b1;
  end

  assign est_o = est_q;
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] loc_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          hash_end_i
);
  logic             loc_ok, wr_vld;
  ctl_cmd_t         cmd;
  logic             own_vld, est;
  logic [LW-1:0]    own_loc, own_disp;
  logic [N_LOC-1:0] seized;
  logic [DW-1:0]    rd_val, rdata_q;

  assign loc_ok = loc_i < LW'(N_LOC);
  assign wr_vld = wr_i && loc_ok && (addr_i == REG_CTRL);
  assign cmd    = ctl_cmd_t'(wdata_i[3:0]);

  loc_owner_ctl #(.N(N_LOC), .IW(LW)) u_own (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_vld_i (wr_vld),
    .wr_loc_i (loc_i),
    .cmd_i    (cmd),
    .own_vld_o(own_vld),
    .own_loc_o(own_loc),
    .seized_o (seized)
  );

  loc_est_flag #(.IW(LW), .PRIV_LOC(PRIV_MIN)) u_est (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_req_i (wr_vld && cmd.rst_est),
    .set_loc_i (loc_i),
    .hash_end_i(hash_end_i),
    .est_o     (est)
  );

  assign own_disp = own_vld ? own_loc : '0;

  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      REG_STAT:  if (loc_ok) rd_val = {{(DW-2){1'b0}}, seized[loc_i], own_vld && own_loc == loc_i};
      REG_STATE: rd_val = {1'b1, {(DW-LW-3){1'b0}}, own_disp, own_vld, est};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk
  import loc_arb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LW-1:0]    loc_i,
  input logic [1:0]       addr_i,
  input logic             wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             rd_i,
  input logic [DW-1:0]    rdata_o,
  input logic             hash_end_i,
  input logic             own_vld,
  input logic [LW-1:0]    own_loc,
  input logic [N_LOC-1:0] seized,
  input logic             est
);
  logic ctl_wr;
  assign ctl_wr = wr_i && addr_i == 2'd0 && loc_i < LW'(N_LOC);

  p_owner_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_vld |-> own_loc < LW'(N_LOC));

  p_seize_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[2] && !wdata_i[1] && own_vld && loc_i > own_loc
    |=> own_vld && own_loc == $past(loc_i));

  p_low_seize_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[2] && !wdata_i[1] && own_vld && loc_i <= own_loc
    |=> own_vld && own_loc == $past(own_loc));

  p_victim_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[2] && !wdata_i[1] && own_vld && loc_i > own_loc
    |=> $countones(seized & ~$past(seized)) == 1);

  p_foreign_relinq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && wdata_i[1] && own_vld && loc_i != own_loc
    |=> own_vld && own_loc == $past(own_loc));

  p_est_priv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(est) |-> $past(ctl_wr && wdata_i[3] && loc_i >= LW'(PRIV_MIN)));

  p_hash_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_end_i |=> !est);

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind loc_arbiter loc_arbiter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .loc_i     (loc_i),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .hash_end_i(hash_end_i),
  .own_vld   (own_vld),
  .own_loc   (own_loc),
  .seized    (seized),
  .est       (est)
);

// File: tb/sim_loc_arbiter.sv
module sim_loc_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] loc_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       hash_end_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  loc_arbiter u0 (.*);

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 read+check, 2 hash-end pulse
    logic [2:0] loc;
    logic [1:0] addr;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h81, 4'd1},   // R1 state after reset
    '{2'd1, 3'd0, 2'd1, 8'h00, 8'h00, 4'd1},   // R1 status clear
    '{2'd0, 3'd1, 2'd0, 8'h01, 8'h00, 4'd2},   // loc1 requests
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h87, 4'd2},   // R2 owner 1
    '{2'd1, 3'd1, 2'd1, 8'h00, 8'h01, 4'd2},   // R2 granted bit
    '{2'd0, 3'd0, 2'd0, 8'h01, 8'h00, 4'd3},   // loc0 queued
    '{2'd0, 3'd2, 2'd0, 8'h01, 8'h00, 4'd3},   // loc2 queued
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h87, 4'd3},   // R3 owner unchanged
    '{2'd0, 3'd0, 2'd0, 8'h02, 8'h00, 4'd4},   // foreign relinquish
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h87, 4'd4},   // R4 ignored
    '{2'd0, 3'd1, 2'd0, 8'h02, 8'h00, 4'd4},   // owner relinquishes
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h8B, 4'd3},   // R3 loc2 wins
    '{2'd1, 3'd0, 2'd1, 8'h00, 8'h00, 4'd3},   // R3 loc0 waits
    '{2'd0, 3'd1, 2'd0, 8'h04, 8'h00, 4'd5},   // lower seize
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h8B, 4'd5},   // R5 ignored
    '{2'd0, 3'd4, 2'd0, 8'h04, 8'h00, 4'd5},   // loc4 seizes
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h93, 4'd5},   // R5 owner 4
    '{2'd1, 3'd2, 2'd1, 8'h00, 8'h02, 4'd6},   // R6 victim flag
    '{2'd0, 3'd4, 2'd0, 8'h02, 8'h00, 4'd3},   // loc4 leaves
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h83, 4'd3},   // R3 queued loc0 granted
    '{2'd1, 3'd2, 2'd1, 8'h00, 8'h02, 4'd6},   // R6 flag persists
    '{2'd0, 3'd2, 2'd0, 8'h01, 8'h00, 4'd6},   // loc2 asks again
    '{2'd1, 3'd2, 2'd1, 8'h00, 8'h00, 4'd6},   // R6 flag cleared
    '{2'd2, 3'd0, 2'd0, 8'h00, 8'h00, 4'd8},   // hash end
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h82, 4'd8},   // R8 est cleared
    '{2'd0, 3'd2, 2'd0, 8'h08, 8'h00, 4'd7},   // non-privileged set
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h82, 4'd7},   // R7 ignored
    '{2'd0, 3'd3, 2'd0, 8'h08, 8'h00, 4'd7},   // loc3 set
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h83, 4'd7},   // R7 est set
    '{2'd1, 3'd0, 2'd0, 8'h00, 8'h00, 4'd9},   // R9 control reads 0
    '{2'd0, 3'd5, 2'd0, 8'h04, 8'h00, 4'd9},   // bad locality seize
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h83, 4'd9},   // R9 ignored
    '{2'd0, 3'd3, 2'd0, 8'h05, 8'h00, 4'd10},  // seize+request
    '{2'd1, 3'd0, 2'd2, 8'h00, 8'h8F, 4'd10},  // R10 owner 3
    '{2'd0, 3'd3, 2'd0, 8'h02, 8'h00, 4'd10}   // loc3 leaves, loc2 next
  };

  task automatic chk(input int rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] l, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    loc_i = l; addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_rd(input logic [2:0] l, input logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i);
    loc_i = l; addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk_i);
    chk(1, rdata_o, 8'h00);  // R1 rdata reset value
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: do_wr(TBL[i].loc, TBL[i].addr, TBL[i].d);
        2'd1: begin
          do_rd(TBL[i].loc, TBL[i].addr, v);
          chk(int'(TBL[i].rq), v, TBL[i].exp);
        end
        default: begin
          @(negedge clk_i); hash_end_i = 1'b1;
          @(negedge clk_i); hash_end_i = 1'b0;
        end
      endcase
    end
    // R10 request part not queued: loc2 (pending) got the module, not loc3
    do_rd(3'd0, 2'd2, v);
    chk(10, v, 8'h8B);
    do_rd(3'd0, 2'd1, v);  // R6 loc0 lost ownership by seize
    chk(6, v, 8'h02);

    // R8 hash-end beats same-cycle privileged set
    @(negedge clk_i);
    loc_i = 3'd4; addr_i = 2'd0; wdata_i = 8'h08; wr_i = 1'b1; hash_end_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; hash_end_i = 1'b0;
    do_rd(3'd0, 2'd2, v);
    chk(8, v, 8'h8A);

    // R9 rdata holds without rd_i while state changes
    do_wr(3'd4, 2'd0, 8'h08);
    repeat (3) @(negedge clk_i);
    chk(9, rdata_o, 8'h8A);
    do_rd(3'd5, 2'd1, v);  // R9 bad locality status reads 0
    chk(9, v, 8'h00);

    // R1 reset mid-run clears owner and seized flags, sets est
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    do_rd(3'd0, 2'd2, v);
    chk(1, v, 8'h81);
    do_rd(3'd0, 2'd1, v);
    chk(1, v, 8'h00);

    // R5 seize with no owner is ignored; R2 request then grants
    do_wr(3'd4, 2'd0, 8'h04);
    do_rd(3'd0, 2'd2, v);
    chk(5, v, 8'h81);
    do_wr(3'd3, 2'd0, 8'h01);
    do_rd(3'd3, 2'd1, v);
    chk(2, v, 8'h01);
    finish_run();
  end
endmodule